// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives an SPI serial clock (SCK) from a faster input clock. It reads a 32-bit configuration word from the transfer engine. One 6-bit field sets the length of each SCK period. A second 6-bit field sets how many input cycles of that period SCK spends high. SCK idles low, which is mode-0 polarity.

Alongside the SCK level the block emits two single-cycle strobes, one for the rising edge and one for the falling edge. The shifter uses them to decide when to sample and when to drive data.

The transfer engine raises `run` for the length of a transfer. Dropping `run` parks SCK low and restarts the phase counter. A new configuration is picked up only at a period boundary, so SCK never emits a runt pulse.

Top module: `spi_sck_divider`

## Requirements
- R1: The period field sits at bits 17:12 of `cfg_word` and the high-count field at bits 11:6. With a period field value n of 1 or more, one SCK period lasts n+1 input clock cycles.
- R2: For high-count value h, SCK is high for the first h+1 input cycles of each period and low for the rest of the period.
- R3: A period field of 0 is treated as 1, so the fastest SCK is the input clock divided by 2. The value 63 gives the slowest SCK, the input clock divided by 64.
- R4: A high count equal to or above the effective period field n is limited to n−1, so every period has at least one low cycle.
- R5: While `run` is low, SCK stays low, both strobes stay low, and the phase counter is held at zero. In the first cycle after an edge that samples `run` high, SCK is high and `sck_rise` is asserted.
- R6: `sck_rise` is high in exactly the cycles where SCK goes from low to high. `sck_fall` is high in exactly the cycles where a running SCK goes from high to low. When dropping `run` forces SCK low, `sck_fall` is not asserted, and the two strobes are never high together.
- R7: The configuration present while idle sets the first period. A configuration change made during a transfer takes effect at the start of the next period, and the period already under way keeps its old timing.
- R8: Bits 31:18, which include the clock-source select in bit 31, and bits 5:0, the low-count field, have no effect on SCK timing.
- R9: During reset, SCK and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that SCK is divided from |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enable from the transfer engine |
| cfg_word | input | 32 | Clock configuration word |
| sck | output | 1 | Serial clock level, idles low |
| sck_rise | output | 1 | One-cycle strobe on the SCK rising edge |
| sck_fall | output | 1 | One-cycle strobe on the SCK falling edge |

## Verification
The bench builds the block with its default parameters: a 32-bit configuration word and 6-bit count fields. These defaults bring within reach both end points of the divide range, /2 and /64, along with the zero-divider floor and the clamp on an oversized high count.

Using the full 6-bit width lets a single transfer run a 64-cycle period, which exercises a period boundary at the top of the counter range. With these defaults the bench also changes the configuration in the middle of a transfer and drops `run` while SCK is high, so that a period boundary and a forced stop are each seen with real field values.

// File: rtl/spi_sck_divider.sv
module spi_sck_divider #(
  parameter int CFG_W = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             sck,
  output logic             sck_rise,
  output logic             sck_fall
);
  localparam int LO_LSB  = 0;
  localparam int HI_LSB  = CNT_W;
  localparam int DIV_LSB = 2 * CNT_W;
  localparam int USED_W  = 3 * CNT_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cfg_div, cfg_hi, div_eff, hi_eff;
  logic [CNT_W-1:0] ph, div_q, hi_q;
  logic             active;

  assign cfg_div = cfg_word[DIV_LSB +: CNT_W];
  assign cfg_hi  = cfg_word[HI_LSB +: CNT_W];
  assign div_eff = (cfg_div == '0) ? ONE : cfg_div;
  assign hi_eff  = (cfg_hi >= div_eff) ? div_eff - ONE : cfg_hi;

  wire unused_cfg = ^{cfg_word[CFG_W-1:USED_W], cfg_word[LO_LSB +: CNT_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      ph     <= '0;
      div_q  <= ONE;
      hi_q   <= '0;
    end else if (!run) begin
      active <= 1'b0;
      ph     <= '0;
      div_q  <= div_eff;
      hi_q   <= hi_eff;
    end else begin
      active <= 1'b1;
      if (active && ph == div_q) begin
        ph    <= '0;
        div_q <= div_eff;
        hi_q  <= hi_eff;
      end else if (active) begin
        ph <= ph + ONE;
      end
    end
  end

  assign sck      = active && (ph <= hi_q);
  assign sck_rise = active && (ph == '0);
  assign sck_fall = active && (ph == hi_q + ONE);
endmodule

// File: rtl/spi_sck_divider_chk.sv
module spi_sck_divider_chk #(
  parameter int CFG_W = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic [CFG_W-1:0] cfg_word,
  input logic             sck,
  input logic             sck_rise,
  input logic             sck_fall
);
  wire unused_chk = ^cfg_word;

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!sck && !sck_rise && !sck_fall)); // R5
  AST_RISE_IS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise == $rose(sck)); // R6
  AST_FALL_IS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    sck_fall |-> (!sck && $past(sck))); // R6
  AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> (sck_fall || !$past(run))); // R6
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sck_rise && sck_fall)); // R6
  AST_MIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |=> !sck_rise); // R3
endmodule

bind spi_sck_divider spi_sck_divider_chk #(.CFG_W(CFG_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .cfg_word(cfg_word),
  .sck(sck), .sck_rise(sck_rise), .sck_fall(sck_fall)
);

// File: tb/tb_spi_sck_divider.sv
module tb_spi_sck_divider;
  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0;
  logic [31:0] cfg_word = '0;
  logic sck, sck_rise, sck_fall;
  int checks = 0, fails = 0;
  bit done = 0;

  spi_sck_divider dut (.clk(clk), .rst_n(rst_n), .run(run), .cfg_word(cfg_word),
                       .sck(sck), .sck_rise(sck_rise), .sck_fall(sck_fall));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int d, input int h, input int lo, input int top);
    logic [13:0] t = top[13:0];
    logic [5:0] dd = d[5:0], hh = h[5:0], ll = lo[5:0];
    return {t, dd, hh, ll};
  endfunction

  // {divider, high, low-count, bits 31:18, expected period, expected high cycles}
  localparam int VEC [8][6] = '{
    '{1,  0,  0, 0,      2,  1},   // R1 fastest legal divider
    '{0,  0,  0, 0,      2,  1},   // R3 zero divider floored to 1
    '{63, 31, 63, 0,     64, 32},  // R3 slowest divider
    '{4,  1,  4, 0,      5,  2},   // R2 short high phase
    '{5,  9,  5, 0,      6,  5},   // R4 high count clamped
    '{7,  3,  7, 8192,   8,  4},   // R8 bit 31 set
    '{2,  2,  0, 0,      3,  2},   // R4 high equals divider
    '{9,  4,  63, 16383, 10, 5}    // R8 all spare bits set
  };

  task automatic measure(input logic [31:0] cfg, input int p, input int h, input int idx);
    int hi_c = 0, r_c = 0, f_c = 0, f_at = -1;
    bit r_end = 0;
    run = 1'b0;
    cfg_word = cfg;
    @(negedge clk);
    @(negedge clk);
    run = 1'b1;
    for (int i = 0; i <= p; i++) begin
      @(negedge clk);
      if (i < p) begin
        hi_c += int'(sck);
        r_c += int'(sck_rise);
        f_c += int'(sck_fall);
        if (sck_fall) f_at = i;
      end else r_end = sck_rise;
    end
    $display("vector %0d", idx);
    chk(hi_c == h, "R2 high cycles per period", hi_c, h);
    chk(r_c == 1 && f_c == 1, "R6 one rise and one fall per period", r_c * 10 + f_c, 11);
    chk(f_at == h, "R6 fall strobe position", f_at, h);
    chk(r_end, "R1 period length", int'(r_end), 1);
    run = 1'b0;
  endtask

  initial begin
    int seen;
    @(negedge clk);
    chk(!sck && !sck_rise && !sck_fall, "R9 reset outputs low", int'(sck | sck_rise | sck_fall), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < 8; v++)
      measure(mk(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]), VEC[v][4], VEC[v][5], v);

    // R5: idle keeps SCK low
    run = 1'b0;
    cfg_word = mk(3, 1, 3, 0);
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      seen += int'(sck | sck_rise | sck_fall);
    end
    chk(seen == 0, "R5 idle outputs low", seen, 0);

    // R5/R6: drop run while SCK is high, then restart
    cfg_word = mk(9, 4, 9, 0);
    run = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(sck, "R5 high before drop", int'(sck), 1);
    run = 1'b0;
    @(negedge clk);
    chk(!sck, "R5 forced low on drop", int'(sck), 0);
    chk(!sck_fall, "R6 no fall strobe on forced stop", int'(sck_fall), 0);
    run = 1'b1;
    @(negedge clk);
    chk(sck && sck_rise, "R5 restart from phase zero", int'(sck & sck_rise), 1);
    run = 1'b0;
    @(negedge clk);

    // R7: mid-run configuration change applies at next period
    cfg_word = mk(3, 1, 3, 0);
    @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    cfg_word = mk(5, 2, 5, 0);
    seen = 0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (i == 4) chk(sck_rise, "R7 old period kept", int'(sck_rise), 1);
      if (i >= 4) seen += int'(sck);
      if (i > 4 && i < 10 && sck_rise) chk(0, "R7 early rise in new period", i, 10);
      if (i == 10) chk(sck_rise, "R7 new period length", int'(sck_rise), 1);
    end
    chk(seen == 4, "R7 new high count", seen, 4);
    run = 1'b0;
    @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule